// File: doc/BRIEF.md
# Bit-Timing Recovery Loop

This block regenerates a receive bit clock from a hard-limited serial data stream and re-times that data onto the recovered clock. A free-running phase counter spans one bit cell of master-clock ticks. Every level change of the incoming data is taken as a bit boundary. The counter value at that moment is the phase error. The counter is then pulled toward the boundary by a step whose size depends on the error, on a fast-correction enable and on a lock-speed select.

The recovered clock `rt` is low for the first half of each cell and high for the second half, so its falling edge marks the expected bit boundary. The data is sampled at mid-cell, where `rt` rises. The sample is presented on `rd` at the next falling edge of `rt`. The default cell length of 3072 ticks gives 1200 bit/s from a 3.6864 MHz master clock. The cell length is a parameter.

Top module: `bit_timing_dpll`

## Requirements
- R1: While `rst` is high at a rising clock edge, the phase counter is cleared and `rd` and all internal data stages go to 0. On the following cycles `rt` reads 0 and `rd` reads 0.
- R2: The phase counter runs 0 to CELL_TICKS-1 and wraps. `rt` is 1 exactly when the count is at least CELL_TICKS/2. With no data transitions, `rt` therefore has a period of CELL_TICKS cycles.
- R3: `din` passes through two synchronizer flops. A transition is recognised when the second and third stages differ. It is judged against the phase count of that cycle, which is two cycles after the change is first registered.
- R4: A transition seen at count p < CELL_TICKS/2 is an early boundary with error p, and the counter is retarded by the step. A transition seen at p >= CELL_TICKS/2 has error CELL_TICKS-p, and the counter is advanced by the step. In both cases the normal +1 increment still applies.
- R5: When `cf` is 1 and the error exceeds CELL_TICKS/16 (22.5 degrees), the step is the error divided by 4, truncated.
- R6: In every other case with `cf` = 1, the step is CELL_TICKS/32 when `ct` is 0 and CELL_TICKS/128 when `ct` is 1. The choice is made again at each transition, so the loop returns to the small step as soon as the error is within the threshold.
- R7: When `cf` is 0, the small step of R6 is always used, whatever the error.
- R8: No step exceeds the error, so a correction never moves the boundary past the transition. `rd` only changes when `rt` falls. It then takes the value of the second synchronizer stage that was sampled when the count equalled CELL_TICKS/2.
- R9: With `cf` = 1 and `ct` = 0, an alternating 1/0 pattern starting with up to half a cell of phase error brings every transition within CELL_TICKS/16 (plus synchronizer delay) of a falling `rt` edge after 18 bits.
- R10: With `cf` = 1 and `ct` = 1, the same lock holds after 50 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, one tick per phase count |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Hard-limited demodulated data, asynchronous |
| cf | input | 1 | Enables the large correction step for large errors |
| ct | input | 1 | Lock-speed select: 1 picks the smaller slow step |
| rt | output | 1 | Recovered bit clock, falling edge at bit boundary |
| rd | output | 1 | Re-timed data, updated at the falling edge of `rt` |

## Verification
The hardest conditions to reach are the switch between step sizes inside a single acquisition and the case where an advance lands exactly on the wrap point. Both occur only when a data edge arrives at a specific phase. The stimulus therefore starts an alternating pattern at a chosen offset of nearly half a cell after reset. This walks the error through the large-step region, across the 1/16 threshold and down to zero, for each combination of `cf` and `ct`. A final stretch of random data with `cf` and `ct` changing mid-stream hits arbitrary phases, while a behavioural model is compared every cycle.

// File: rtl/bit_timing_dpll.sv
module bit_timing_dpll #(
  parameter int CELL_TICKS = 3072
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic cf,
  input  logic ct,
  output logic rt,
  output logic rd
);
  localparam int W     = $clog2(CELL_TICKS);
  localparam int HALF  = CELL_TICKS / 2;
  localparam int THR   = CELL_TICKS / 16;
  localparam int SLOW0 = CELL_TICKS / 32;
  localparam int SLOW1 = CELL_TICKS / 128;

  logic [W-1:0] ph;
  logic [W:0]   err, base, step, inc, sum, nxt;
  logic         s1, s2, s3, smp, late, fast, edge_s, wrap;

  assign edge_s = s2 ^ s3;
  assign late   = ph < W'(HALF);
  assign err    = late ? {1'b0, ph} : ((W+1)'(CELL_TICKS) - {1'b0, ph});
  assign fast   = cf && (err > (W+1)'(THR));
  assign base   = fast ? (err >> 2) : (ct ? (W+1)'(SLOW1) : (W+1)'(SLOW0));
  assign step   = (base > err) ? err : base;
  assign inc    = {1'b0, ph} + 1'b1;
  assign sum    = !edge_s ? inc : (late ? inc - step : inc + step);
  assign wrap   = sum >= (W+1)'(CELL_TICKS);
  assign nxt    = wrap ? sum - (W+1)'(CELL_TICKS) : sum;
  assign rt     = !late;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph  <= '0;
      s1  <= 1'b0;
      s2  <= 1'b0;
      s3  <= 1'b0;
      smp <= 1'b0;
      rd  <= 1'b0;
    end else begin
      s1 <= din;
      s2 <= s1;
      s3 <= s2;
      ph <= nxt[W-1:0];
      if (ph == W'(HALF)) smp <= s2;
      if (wrap) rd <= smp;
    end
  end

  p_phase_range_r2: assert property (@(posedge clk) disable iff (rst)
    int'(ph) < CELL_TICKS);

  p_free_run_r2: assert property (@(posedge clk) disable iff (rst)
    (!edge_s && int'(ph) < CELL_TICKS - 1) |=> int'(ph) == int'($past(ph)) + 1);

  p_retard_bounded_r4: assert property (@(posedge clk) disable iff (rst)
    (edge_s && late) |=> (int'(ph) <= int'($past(ph)) + 1 && !rt));

  p_cf_off_small_r7: assert property (@(posedge clk) disable iff (rst)
    (edge_s && late && !cf) |=> (int'($past(ph)) + 1 - int'(ph)) <= SLOW0);

  p_rd_at_fall_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(rd) |-> $fell(rt));
endmodule

// File: tb/test_bit_timing_dpll.sv
module test_bit_timing_dpll;
  localparam int CELL = 256;
  localparam int HALF = CELL / 2;
  localparam int THR  = CELL / 16;

  logic clk = 0, rst = 1, din = 0, cf = 0, ct = 0;
  logic rt, rd;
  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  bit_timing_dpll #(.CELL_TICKS(CELL)) i_bit_timing_dpll (
    .clk(clk), .rst(rst), .din(din), .cf(cf), .ct(ct), .rt(rt), .rd(rd));

  always #10 clk = ~clk;

  int m_ph = 0, m_nx, m_e, m_b, m_st;
  bit m_s1 = 0, m_s2 = 0, m_s3 = 0, m_smp = 0, m_rd = 0;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_ph = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_smp = 0; m_rd = 0;
    end else begin
      m_nx = m_ph + 1;
      if (m_s2 != m_s3) begin
        m_e = (m_ph < HALF) ? m_ph : CELL - m_ph;
        if (cf && m_e > THR) m_b = m_e / 4;
        else m_b = ct ? CELL / 128 : CELL / 32;
        m_st = (m_b > m_e) ? m_e : m_b;
        m_nx = (m_ph < HALF) ? m_nx - m_st : m_nx + m_st;
      end
      if (m_ph == HALF) m_smp = m_s2;
      if (m_nx >= CELL) begin m_nx -= CELL; m_rd = m_smp; end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = din; m_ph = m_nx;
    end
  end

  string tag = "R2 R3 R4";
  bit cmp_on = 0, lock_on = 0, pend = 0, rt_prev = 0;
  int tog_cyc = 0, prev_fall = 0, d0, d1, lerr;
  string lock_tag = "R9";

  always @(negedge clk) begin
    if (cmp_on) begin
      total++;
      if (rt !== (m_ph >= HALF)) begin
        bad++;
        $display("FAIL %s rt actual=%0b expected=%0b cyc=%0d", tag, rt, m_ph >= HALF, cyc);
      end
      total++;
      if (rd !== m_rd) begin
        bad++;
        $display("FAIL R8 rd actual=%0b expected=%0b cyc=%0d", rd, m_rd, cyc);
      end
    end
    if (rt_prev && !rt) begin
      if (pend && cyc >= tog_cyc) begin
        d1 = cyc - tog_cyc;
        d0 = tog_cyc - prev_fall;
        lerr = (d0 < d1) ? d0 : d1;
        if (lock_on) begin
          total++;
          if (lerr > THR + 3) begin
            bad++;
            $display("FAIL %s lock error actual=%0d expected<=%0d", lock_tag, lerr, THR + 3);
          end
        end
        pend = 0;
      end
      prev_fall = cyc;
    end
    rt_prev = rt;
  end

  task automatic do_reset();
    cmp_on = 0; lock_on = 0; pend = 0;
    @(negedge clk); rst = 1; din = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    total++;
    if (rt !== 1'b0 || rd !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset rt/rd actual=%0b%0b expected=00", rt, rd);
    end
    cmp_on = 1;
  endtask

  task automatic run_alt(input bit f, input bit t, input int offset,
                         input int nbits, input int lockbits, input string ltag);
    cf = f; ct = t;
    tag = f ? (t ? "R2 R3 R4 R5 R6 ct1" : "R2 R3 R4 R5 R6 ct0") : "R2 R3 R4 R7";
    lock_tag = ltag;
    do_reset();
    repeat (offset) @(negedge clk);
    for (int b = 0; b < nbits; b++) begin
      din = ~din;
      tog_cyc = cyc;
      pend = 1;
      lock_on = (lockbits > 0) && (b >= lockbits);
      repeat (CELL) @(negedge clk);
    end
    lock_on = 0;
  endtask

  initial begin
    run_alt(1, 0, HALF - 10, 40, 18, "R9");
    run_alt(1, 1, HALF - 10, 70, 50, "R10");
    run_alt(0, 0, HALF + 30, 30, 0, "");
    run_alt(0, 1, 40, 30, 0, "");
    tag = "R2 R3 R4 R5 R6 R7 mixed";
    do_reset();
    repeat (77) @(negedge clk);
    for (int b = 0; b < 120; b++) begin
      din = $urandom_range(0, 1);
      if (b % 9 == 0) begin cf = $urandom_range(0, 1); ct = $urandom_range(0, 1); end
      repeat (CELL - 3 + $urandom_range(0, 6)) @(negedge clk);
    end
    repeat (2 * CELL) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #3_800_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule